// File: doc/BRIEF.md
# Link Payload Mode Multiplexer

This block forms the 32-bit payload word for each of three serial link transmitters. It produces one word per clock, and each clock is one bunch crossing. Two 36-bit trigger-primitive sources feed it: source A from the upper half of the board and source B from the lower half. A map-select register chooses how trigger bits are routed onto the low field of each link. A mode register chooses what goes on top of that field. The choices are plain routed data, an 8-bit interleaved parity code, the crossing number together with the orbit marker, a programmable test word, pseudo-random test data, the idle pattern, or the factory test pattern.

Every output is registered. A word therefore shows the inputs of the previous clock. A change to the mode or map register appears in the very next word, and the transmitters do not need a reset. When idle or factory test is selected, the block raises a per-link request flag and clears the data word. The transmitter then creates the pattern itself. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `link_payload_mux`

## Requirements
- R1: While reset is asserted, every link word reads zero and every idle and factory request flag is low.
- R2: When mode bits 5..0 are all zero, each link carries 19 routed bits on bits 18..0 and zeros on bits 31..19. Map 0x00 routes A[18:0] to links 0 and 2 and B[18:0] to link 1. Map 0x01 routes B[18:0] to links 0 and 2 and A[18:0] to link 1.
- R3: Maps 0xFC, 0xFD, 0xFE and 0xFF each place one slice on bits 17..0 of all three links, with bit 18 zero. The slices are A[17:0], A[35:18], B[17:0] and B[35:18], in that order.
- R4: Map values 0x02 through 0xFB give an all-zero routed field.
- R5: Mode bit 0 places a check code on bits 31..24 over the routed word. Check bit k (k = 0..7) is the XOR of word bits k, k+8 and k+16.
- R6: Mode bit 1 places the crossing counter bits 6..0 on bits 31..25 and the orbit-marker flag on bit 24, above the routed field. Bit 1 takes priority over bit 0.
- R7: Mode bit 3 without bit 2 sends the 32-bit test word unchanged on all links. It takes priority over bits 1 and 0.
- R8: Mode bits 3 and 2 together send pseudo-random data on all links. Bits 30..0 hold a 31-bit LFSR state and bit 31 is zero. The state is never zero and steps once per word. Each new state is the previous state shifted up by one, with bit 0 set to the XOR of the previous bits 30 and 27 (x^31+x^28+1).
- R9: Mode bit 2 without bit 3 has no effect, and mode bits 7 and 6 have no effect.
- R10: Mode bit 4 raises the idle flag on all three links and clears the link words. It takes priority over bits 3..0.
- R11: Mode bit 5 raises the factory test flag on all three links and clears the idle flags and link words. It takes priority over every other mode bit.
- R12: Each word reflects the inputs sampled one clock earlier. A mode or map change appears in the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word (bunch-crossing) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 36 | Trigger primitives, source A (top) |
| src_b | input | 36 | Trigger primitives, source B (bottom) |
| mode_reg | input | 8 | Payload mode bits |
| map_sel | input | 8 | Routing map select |
| test_word | input | 32 | Programmable test pattern |
| bx_count | input | 12 | Bunch-crossing counter value |
| bc0_flag | input | 1 | Orbit marker for this crossing |
| link_data | output | 96 | Link words, link n at bits 32n+31..32n |
| link_idle | output | 3 | Per-link idle pattern request |
| link_ftest | output | 3 | Per-link factory test pattern request |

## Verification
Every result is due exactly one clock after the inputs that produce it, because each link has a single output register. The driver sets inputs on the falling edge and queues the expected word. The monitor takes that item off the queue 1 ns after the next rising edge, so every comparison falls on the cycle in which the register has just loaded. Pseudo-random words have no fixed expected value. For these the bench checks the LFSR recurrence between back-to-back random words. The mode sequences run back to back, so any change that is late or early by one word shows up as a mismatch.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int NLINK   = 3;
  localparam int WORD_W  = 32;
  localparam int TP_W    = 36;
  localparam int ROUTE_W = 19;
  localparam int NARROW_W = 18;
  localparam int CHK_W   = 8;
  localparam int LO_W    = 24;
  localparam int XN_W    = 7;
  localparam int PRBS_W  = 31;

  typedef enum logic [2:0] {
    K_PLAIN, K_CHK, K_XNUM, K_TWORD, K_PRBS, K_IDLE, K_FTEST
  } kind_t;

  function automatic kind_t decode_mode(input logic [7:0] m);
    kind_t k;
    if (m[5])             k = K_FTEST;
    else if (m[4])        k = K_IDLE;
    else if (m[3] && m[2]) k = K_PRBS;
    else if (m[3])        k = K_TWORD;
    else if (m[1])        k = K_XNUM;
    else if (m[0])        k = K_CHK;
    else                  k = K_PLAIN;
    return k;
  endfunction
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/lpm_prbs.sv
module lpm_prbs #(
  parameter int W    = 31,
  parameter int TAP  = 28,
  parameter logic [W-1:0] SEED = {{(W-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = state_q[W-1] ^ state_q[TAP-1];
    state_d = state_q;
    if (step_en) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  a_r8_state_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> state_q == {$past(state_q[W-2:0]), $past(state_q[W-1] ^ state_q[TAP-1])});
endmodule

// File: rtl/lpm_router.sv
module lpm_router
  import lpm_pkg::*;
(
  input  logic [7:0]                       map_sel,
  input  logic [TP_W-1:0]                  src_a,
  input  logic [TP_W-1:0]                  src_b,
  output logic [NLINK-1:0][ROUTE_W-1:0]    route
);
  localparam int PAD_W = ROUTE_W - NARROW_W;

  logic [ROUTE_W-1:0] broadcast;

  always_comb begin
    case (map_sel)
      8'hFC:   broadcast = {{PAD_W{1'b0}}, src_a[NARROW_W-1:0]};
      8'hFD:   broadcast = {{PAD_W{1'b0}}, src_a[2*NARROW_W-1:NARROW_W]};
      8'hFE:   broadcast = {{PAD_W{1'b0}}, src_b[NARROW_W-1:0]};
      8'hFF:   broadcast = {{PAD_W{1'b0}}, src_b[2*NARROW_W-1:NARROW_W]};
      default: broadcast = '0;
    endcase
  end

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    localparam bit EVEN = (i % 2) == 0;
    logic [ROUTE_W-1:0] alt_first;
    logic [ROUTE_W-1:0] alt_second;
    assign alt_first  = EVEN ? src_a[ROUTE_W-1:0] : src_b[ROUTE_W-1:0];
    assign alt_second = EVEN ? src_b[ROUTE_W-1:0] : src_a[ROUTE_W-1:0];
    always_comb begin
      if (map_sel == 8'h00)      route[i] = alt_first;
      else if (map_sel == 8'h01) route[i] = alt_second;
      else                       route[i] = broadcast;
    end
  end
endmodule

// File: rtl/lpm_overlay.sv
module lpm_overlay
  import lpm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  kind_t               kind,
  input  logic [ROUTE_W-1:0]  route,
  input  logic [WORD_W-1:0]   test_word,
  input  logic [PRBS_W-1:0]   prbs,
  input  logic [XN_W-1:0]     xnum,
  input  logic                bc0,
  output logic [WORD_W-1:0]   data_q,
  output logic                idle_q,
  output logic                ftest_q
);
  localparam int GROUPS = LO_W / CHK_W;

  logic [LO_W-1:0]   low_field;
  logic [CHK_W-1:0]  chk;
  logic [WORD_W-1:0] data_d;
  logic              idle_d;
  logic              ftest_d;

  assign low_field = {{(LO_W-ROUTE_W){1'b0}}, route};

  always_comb begin
    chk = '0;
    for (int g = 0; g < GROUPS; g++) chk ^= low_field[g*CHK_W +: CHK_W];
  end

  always_comb begin
    data_d  = '0;
    idle_d  = 1'b0;
    ftest_d = 1'b0;
    case (kind)
      K_FTEST: ftest_d = 1'b1;
      K_IDLE:  idle_d  = 1'b1;
      K_PRBS:  data_d  = {{(WORD_W-PRBS_W){1'b0}}, prbs};
      K_TWORD: data_d  = test_word;
      K_XNUM:  data_d  = {xnum, bc0, low_field};
      K_CHK:   data_d  = {chk, low_field};
      default: data_d  = {{(WORD_W-LO_W){1'b0}}, low_field};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      idle_q  <= 1'b0;
      ftest_q <= 1'b0;
    end else begin
      data_q  <= data_d;
      idle_q  <= idle_d;
      ftest_q <= ftest_d;
    end
  end

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_q && ftest_q));
  a_r10_flag_clears_word: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q || ftest_q) |-> data_q == '0);
endmodule

// File: rtl/link_payload_mux.sv
module link_payload_mux
  import lpm_pkg::*;
#(
  parameter int BXW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TP_W-1:0]         src_a,
  input  logic [TP_W-1:0]         src_b,
  input  logic [7:0]              mode_reg,
  input  logic [7:0]              map_sel,
  input  logic [WORD_W-1:0]       test_word,
  input  logic [BXW-1:0]          bx_count,
  input  logic                    bc0_flag,
  output logic [NLINK*WORD_W-1:0] link_data,
  output logic [NLINK-1:0]        link_idle,
  output logic [NLINK-1:0]        link_ftest
);
  logic                       rst_q;
  logic [PRBS_W-1:0]          prbs;
  logic [NLINK-1:0][ROUTE_W-1:0] route;
  kind_t                      kind;

  assign kind = decode_mode(mode_reg);

  lpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  lpm_prbs #(.W(PRBS_W), .TAP(28)) u_prbs (
    .clk     (clk),
    .rst_n   (rst_q),
    .step_en (1'b1),
    .state   (prbs)
  );

  lpm_router u_route (
    .map_sel (map_sel),
    .src_a   (src_a),
    .src_b   (src_b),
    .route   (route)
  );

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    lpm_overlay u_ovl (
      .clk       (clk),
      .rst_n     (rst_q),
      .kind      (kind),
      .route     (route[i]),
      .test_word (test_word),
      .prbs      (prbs),
      .xnum      (bx_count[XN_W-1:0]),
      .bc0       (bc0_flag),
      .data_q    (link_data[i*WORD_W +: WORD_W]),
      .idle_q    (link_idle[i]),
      .ftest_q   (link_ftest[i])
    );

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_q)
      (mode_reg[5:0] == 6'd0) |=> link_data[i*WORD_W+ROUTE_W +: WORD_W-ROUTE_W] == '0);
  end

  a_r11_factory_all: assert property (@(posedge clk) disable iff (!rst_q)
    mode_reg[5] |=> (&link_ftest) && (link_idle == '0));
  a_r10_idle_all: assert property (@(posedge clk) disable iff (!rst_q)
    (!mode_reg[5] && mode_reg[4]) |=> (&link_idle) && (link_ftest == '0));
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_reg[5:0] == 6'd0 && map_sel >= 8'h02 && map_sel <= 8'hFB) |=> link_data == '0);
  a_r7_test_word: assert property (@(posedge clk) disable iff (!rst_q)
    (mode_reg[5:2] == 4'b0010) |=> link_data[WORD_W-1:0] == $past(test_word));
endmodule

// File: tb/link_payload_mux_test.sv
module link_payload_mux_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [35:0] src_a, src_b;
  logic [7:0]  mode_reg, map_sel;
  logic [31:0] test_word;
  logic [11:0] bx_count;
  logic        bc0_flag;
  logic [95:0] link_data;
  logic [2:0]  link_idle, link_ftest;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [95:0] d;
    logic [2:0]  idle;
    logic [2:0]  ft;
    bit          rnd;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t e;
  logic [30:0] prev_rnd;
  bit          prev_valid = 1'b0;

  always #2 clk = ~clk;

  link_payload_mux uut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .mode_reg(mode_reg), .map_sel(map_sel), .test_word(test_word),
    .bx_count(bx_count), .bc0_flag(bc0_flag),
    .link_data(link_data), .link_idle(link_idle), .link_ftest(link_ftest)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] route_exp(int i, logic [7:0] mp, logic [35:0] a, logic [35:0] b);
    case (mp)
      8'h00:   return (i % 2 == 0) ? a[18:0] : b[18:0];
      8'h01:   return (i % 2 == 0) ? b[18:0] : a[18:0];
      8'hFC:   return {1'b0, a[17:0]};
      8'hFD:   return {1'b0, a[35:18]};
      8'hFE:   return {1'b0, b[17:0]};
      8'hFF:   return {1'b0, b[35:18]};
      default: return 19'd0;
    endcase
  endfunction

  task automatic drive(input logic [7:0] m, input logic [7:0] mp, input logic [35:0] a,
                       input logic [35:0] b, input logic [31:0] tp, input logic [11:0] bx,
                       input logic bc, input string req);
    exp_t x;
    @(negedge clk);
    mode_reg = m; map_sel = mp; src_a = a; src_b = b;
    test_word = tp; bx_count = bx; bc0_flag = bc;
    x.d = '0; x.idle = '0; x.ft = '0; x.rnd = 1'b0; x.req = req;
    for (int i = 0; i < 3; i++) begin
      logic [23:0] lo;
      logic [7:0]  par;
      logic [31:0] w;
      lo = {5'd0, route_exp(i, mp, a, b)};
      for (int k = 0; k < 8; k++) par[k] = lo[k] ^ lo[k+8] ^ lo[k+16];
      if (m[5])              begin x.ft[i] = 1'b1; w = '0; end
      else if (m[4])         begin x.idle[i] = 1'b1; w = '0; end
      else if (m[3] && m[2]) begin x.rnd = 1'b1; w = '0; end
      else if (m[3])         w = tp;
      else if (m[1])         w = {bx[6:0], bc, lo};
      else if (m[0])         w = {par, lo};
      else                   w = {8'd0, lo};
      x.d[i*32 +: 32] = w;
    end
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      if (e.rnd) begin
        logic [30:0] cur;
        cur = link_data[30:0];
        check(link_idle == 3'b0 && link_ftest == 3'b0, e.req, {90'd0, link_idle, link_ftest}, 96'd0);
        check(link_data[95:64] == link_data[31:0] && link_data[63:32] == link_data[31:0],
              e.req, link_data, {3{link_data[31:0]}});
        check(link_data[31] == 1'b0 && cur != 31'd0, e.req, link_data, 96'd0);
        if (prev_valid)
          check(cur == {prev_rnd[29:0], prev_rnd[30] ^ prev_rnd[27]}, e.req,
                {65'd0, cur}, {65'd0, prev_rnd[29:0], prev_rnd[30] ^ prev_rnd[27]});
        prev_rnd   = cur;
        prev_valid = 1'b1;
      end else begin
        prev_valid = 1'b0;
        check(link_data == e.d, e.req, link_data, e.d);
        check(link_idle == e.idle && link_ftest == e.ft, e.req,
              {90'd0, link_idle, link_ftest}, {90'd0, e.idle, e.ft});
      end
    end
  end

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [35:0] a1, b1;
    a1 = 36'h9_ABCD_E123;
    b1 = 36'h6_1357_9BDF;
    rst_n = 1'b1; mode_reg = 0; map_sel = 0; src_a = a1; src_b = b1;
    test_word = 0; bx_count = 0; bc0_flag = 0;
    #1 rst_n = 1'b0;
    #1;
    // R1: reset state
    check(link_data == '0 && link_idle == 0 && link_ftest == 0, "R1", link_data, 96'd0);
    repeat (3) @(negedge clk);
    check(link_data == '0 && link_idle == 0 && link_ftest == 0, "R1", link_data, 96'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 plain maps, R12 back-to-back changes
    drive(8'h00, 8'h00, a1, b1, 0, 0, 0, "R2");
    drive(8'h00, 8'h01, a1, b1, 0, 0, 0, "R2/R12");
    drive(8'h00, 8'h00, b1, a1, 0, 0, 0, "R2");
    // R3 broadcast maps
    drive(8'h00, 8'hFC, a1, b1, 0, 0, 0, "R3");
    drive(8'h00, 8'hFD, a1, b1, 0, 0, 0, "R3");
    drive(8'h00, 8'hFE, a1, b1, 0, 0, 0, "R3");
    drive(8'h00, 8'hFF, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 0, 0, 0, "R3");
    // R4 reserved maps
    drive(8'h00, 8'h02, a1, b1, 0, 0, 0, "R4");
    drive(8'h00, 8'h80, a1, b1, 0, 0, 0, "R4");
    drive(8'h00, 8'hFB, a1, b1, 0, 0, 0, "R4");
    // R5 check code
    drive(8'h01, 8'h00, a1, b1, 0, 0, 0, "R5");
    drive(8'h01, 8'hFD, 36'hF_FFFF_FFFF, b1, 0, 0, 0, "R5");
    // R6 crossing number and orbit marker, priority over bit 0
    drive(8'h02, 8'h01, a1, b1, 0, 12'hF85, 1, "R6");
    drive(8'h03, 8'h00, a1, b1, 0, 12'h07F, 0, "R6");
    // R7 test word, priority over bits 1,0
    drive(8'h08, 8'h00, a1, b1, 32'hDEAD_BEEF, 12'h123, 1, "R7");
    drive(8'h0B, 8'h00, a1, b1, 32'h0F0F_A5A5, 0, 0, "R7");
    // R9 bit 2 alone, bits 7..6 ignored
    drive(8'h04, 8'h00, a1, b1, 32'hFFFF_FFFF, 0, 0, "R9");
    drive(8'hC0, 8'h01, a1, b1, 32'hFFFF_FFFF, 0, 0, "R9");
    drive(8'hC1, 8'hFE, a1, b1, 0, 0, 0, "R9");
    // R8 pseudo-random run
    for (int n = 0; n < 12; n++) drive(8'h0C, 8'h00, a1, b1, 32'h1234_5678, 0, 0, "R8");
    drive(8'h0F, 8'h00, a1, b1, 0, 0, 0, "R8");
    // R10 idle, priority over test and check
    drive(8'h10, 8'h00, a1, b1, 0, 0, 0, "R10");
    drive(8'h1F, 8'h01, a1, b1, 32'hFFFF_FFFF, 12'hFFF, 1, "R10");
    // R11 factory test, priority over all
    drive(8'h20, 8'h00, a1, b1, 0, 0, 0, "R11");
    drive(8'h3F, 8'hFF, a1, b1, 32'hFFFF_FFFF, 12'hFFF, 1, "R11");
    // R12 recovery to plain data on the next word
    drive(8'h00, 8'hFC, a1, b1, 0, 0, 0, "R12");
    drive(8'h10, 8'hFC, a1, b1, 0, 0, 0, "R12");
    drive(8'h00, 8'h00, a1, b1, 0, 0, 0, "R12");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule